// File: doc/BRIEF.md
# Programmable System Clock Controller

This block derives the system clock enable for a chip from one of two clock sources. Two single-cycle enable inputs stand in for the sources. The first is a crystal oscillator tick, which is held low while the chip is powered down. The second is a 48 MHz tick from a PLL. All logic runs on one fast free-running clock, and each source appears as a per-cycle enable.

Two registers on a byte-wide write/read bus control the block. The control register holds two fields. A 5-bit prescaler code, set to the oscillator frequency in MHz minus one, sets how many oscillator ticks make one PLL reference strobe, so the strobe lands near 1 MHz. A 3-bit divider code picks a power-of-two ratio from 1 to 128. A source register picks which tick stream feeds that divider.

The divided clock leaves the block as a single-cycle enable, `sys_ce`, that coincides with a tick of the chosen source. The PLL tick is also passed straight to the USB side on its own output, unaffected by the divider.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, address C7h reads 58h (prescaler code 01011b, divider code 000), the source register reads 00h, and `sys_ce` follows the oscillator tick.
- R2: The control register at C7h takes a write in one cycle, and `bus_rdata` shows the new value from the next cycle. Bits [7:3] hold the prescaler code and bits [2:0] hold the divider code.
- R3: The source register at C8h keeps only bit 0 (1 = PLL tick, 0 = oscillator tick), and its other bits read 0. Writes to any other address change nothing, and reads of any other address return 00h.
- R4: `pll_ref_stb` is high only in a cycle with `osc_tick` high. It is high on every (P+1)-th oscillator tick, where P is the prescaler code in force.
- R5: A new prescaler code takes effect only after the current reference period ends with a strobe.
- R6: With divider code k, `sys_ce` is high on every 2^k-th tick of the selected source, and only in a cycle where that tick is high.
- R7: With divider code 000, `sys_ce` equals the selected source tick in every cycle.
- R8: Source bit 1 makes the divider count `pll_tick`. Source bit 0 makes it count `osc_tick`.
- R9: A change of divider code or source bit takes effect only at the next `sys_ce` pulse of the setting in force.
- R10: `usb_ce` equals `pll_tick` in every cycle, whatever the register settings.
- R11: While `osc_tick` stays low (power-down), no `pll_ref_stb` appears, and an oscillator-sourced divider emits no `sys_ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | Oscillator clock edge enable |
| pll_tick | input | 1 | 48 MHz PLL clock edge enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| pll_ref_stb | output | 1 | PLL reference strobe |
| sys_ce | output | 1 | Divided system clock enable |
| usb_ce | output | 1 | PLL tick passed to USB logic |

## Verification
`pll_ref_stb`, `sys_ce`, `usb_ce` and `bus_rdata` are combinational on the present inputs and the registered state. The bench therefore drives each cycle's inputs after the falling edge and compares these outputs a moment later, in the same cycle. A register write shows up in `bus_rdata` one cycle after its strobe. A new divider or prescaler setting first shows in the cycle after the boundary pulse that loads it. The bench model applies its updates in the same order: strobe and boundary from the old state, reload from the pre-write registers, then the write.

// File: rtl/sck_pkg.sv
package sck_pkg;
    localparam int PRE_W  = 5;
    localparam int SEL_W  = 3;
    localparam int DATA_W = PRE_W + SEL_W;
    localparam int CNT_W  = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              src;
    } regs_t;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
        logic [PRE_W-1:0] lim;
    } pre_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             src;
    } div_t;
endpackage

// File: rtl/sck_regs.sv
module sck_regs
    import sck_pkg::*;
#(
    parameter logic [7:0]        CTRL_ADDR = 8'hC7,
    parameter logic [7:0]        SRC_ADDR  = 8'hC8,
    parameter logic [DATA_W-1:0] CTRL_RST  = 8'h58
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic              src_q
);
    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr && addr == CTRL_ADDR) r_d.ctrl = wdata;
        if (wr && addr == SRC_ADDR)  r_d.src  = wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= CTRL_RST;
            r_q.src  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (addr == CTRL_ADDR)     rdata = r_q.ctrl;
        else if (addr == SRC_ADDR) rdata = {{(DATA_W-1){1'b0}}, r_q.src};
        else                       rdata = '0;
    end

    assign ctrl_q = r_q.ctrl;
    assign src_q  = r_q.src;
endmodule

// File: rtl/sck_prescaler.sv
module sck_prescaler
    import sck_pkg::*;
#(
    parameter logic [PRE_W-1:0] LIM_RST = 5'd11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [PRE_W-1:0] code,
    output logic             stb
);
    pre_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        stb = tick && (p_q.cnt == p_q.lim);
        if (stb) begin
            p_d.cnt = '0;
            p_d.lim = code;
        end else if (tick) begin
            p_d.cnt = p_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.cnt <= '0;
            p_q.lim <= LIM_RST;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/sck_divider.sv
module sck_divider
    import sck_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             pll_tick,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             src_in,
    output logic             ce
);
    div_t d_d, d_q;
    logic             tick;
    logic [CNT_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) mask[i] = (i < int'(d_q.sel));
    end

    always_comb begin
        d_d  = d_q;
        tick = d_q.src ? pll_tick : osc_tick;
        ce   = tick && (d_q.cnt == mask);
        if (ce) begin
            d_d.cnt = '0;
            d_d.sel = sel_in;
            d_d.src = src_in;
        end else if (tick) begin
            d_d.cnt = d_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
        end else begin
            d_q <= d_d;
        end
    end
endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sck_pkg::*;
#(
    parameter logic [7:0] CTRL_ADDR = 8'hC7,
    parameter logic [7:0] SRC_ADDR  = 8'hC8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              pll_tick,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pll_ref_stb,
    output logic              sys_ce,
    output logic              usb_ce
);
    logic [DATA_W-1:0] ctrl_q;
    logic              src_q;

    sck_regs #(
        .CTRL_ADDR (CTRL_ADDR),
        .SRC_ADDR  (SRC_ADDR),
        .CTRL_RST  ({5'd11, 3'd0})
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .ctrl_q (ctrl_q),
        .src_q  (src_q)
    );

    sck_prescaler #(.LIM_RST(5'd11)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (osc_tick),
        .code  (ctrl_q[DATA_W-1:SEL_W]),
        .stb   (pll_ref_stb)
    );

    sck_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .pll_tick (pll_tick),
        .sel_in   (ctrl_q[SEL_W-1:0]),
        .src_in   (src_q),
        .ce       (sys_ce)
    );

    assign usb_ce = pll_tick;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk #(
    parameter logic [7:0] CTRL_ADDR = 8'hC7,
    parameter logic [7:0] SRC_ADDR  = 8'hC8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_tick,
    input logic       pll_tick,
    input logic       bus_wr,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       pll_ref_stb,
    input logic       sys_ce,
    input logic [7:0] ctrl_q,
    input logic       src_q
);
    // R4, R11: reference strobe only on an oscillator tick
    a_r4_stb_on_osc: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ref_stb |-> osc_tick);

    // R6: the divided enable needs a source tick
    a_r6_ce_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce |-> (osc_tick || pll_tick));

    // R2: control write lands next cycle
    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_ADDR) |=> (ctrl_q == $past(bus_wdata)));

    // R3: source write keeps bit 0
    a_r3_src_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == SRC_ADDR) |=> (src_q == $past(bus_wdata[0])));

    // R3: source bit holds without its write
    a_r3_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == SRC_ADDR) |=> $stable(src_q));
endmodule

bind sysclk_ctrl sysclk_ctrl_chk #(
    .CTRL_ADDR (CTRL_ADDR),
    .SRC_ADDR  (SRC_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_tick    (osc_tick),
    .pll_tick    (pll_tick),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pll_ref_stb (pll_ref_stb),
    .sys_ce      (sys_ce),
    .ctrl_q      (ctrl_q),
    .src_q       (src_q)
);

// File: tb/sysclk_ctrl_tb.sv
module sysclk_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0, pll_tick = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       pll_ref_stb, sys_ce, usb_ce;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_ctrl;
    logic       m_src;
    logic [4:0] m_pcnt, m_plim;
    logic [6:0] m_dcnt;
    logic [2:0] m_sel;
    logic       m_dsrc;

    always #5 clk = ~clk;

    sysclk_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pll_ref_stb(pll_ref_stb), .sys_ce(sys_ce),
        .usb_ce(usb_ce)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] ratio_mask(input logic [2:0] k);
        return 7'((8'd1 << k) - 8'd1);
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'hC7) return m_ctrl;
        if (a == 8'hC8) return {7'd0, m_src};
        return 8'h00;
    endfunction

    // one cycle: drive after negedge, check, update model, pass posedge
    task automatic step(input logic osc, input logic pll, input logic wr,
                        input logic [7:0] a, input logic [7:0] d, input string tag);
        logic tk, e_ce, e_stb;
        @(negedge clk);
        osc_tick = osc; pll_tick = pll; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        tk    = m_dsrc ? pll : osc;
        e_ce  = tk && (m_dcnt == ratio_mask(m_sel));
        e_stb = osc && (m_pcnt == m_plim);
        chk({tag, " R6 R7 R8 sys_ce"}, {7'd0, sys_ce}, {7'd0, e_ce});
        chk({tag, " R4 R5 ref_stb"}, {7'd0, pll_ref_stb}, {7'd0, e_stb});
        chk("R10 usb_ce", {7'd0, usb_ce}, {7'd0, pll});
        chk("R3 rdata", bus_rdata, exp_rd(a));
        if (e_stb) begin m_pcnt = 0; m_plim = m_ctrl[7:3]; end
        else if (osc) m_pcnt = m_pcnt + 1;
        if (e_ce) begin m_dcnt = 0; m_sel = m_ctrl[2:0]; m_dsrc = m_src; end
        else if (tk) m_dcnt = m_dcnt + 1;
        if (wr && a == 8'hC7) m_ctrl = d;
        if (wr && a == 8'hC8) m_src = d[0];
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        m_ctrl = 8'h58; m_src = 0; m_pcnt = 0; m_plim = 5'd11;
        m_dcnt = 0; m_sel = 0; m_dsrc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        step(0, 0, 0, 8'hC7, 0, "R1"); chk("R1 ctrl reset", bus_rdata, 8'h58);
        step(0, 0, 0, 8'hC8, 0, "R1"); chk("R1 src reset", bus_rdata, 8'h00);
        // R7 ratio 1 continuous, R4 strobe on 12th tick
        for (int i = 0; i < 30; i++) begin
            step(1, i[0], 0, 8'h00, 0, "R7");
            chk("R7 ce continuous", {7'd0, sys_ce}, 8'd1);
        end
        // R3 writes to other addresses ignored
        step(1, 0, 1, 8'hC6, 8'hFF, "R3");
        step(1, 0, 1, 8'hC9, 8'hFF, "R3");
        step(0, 0, 0, 8'hC7, 0, "R3"); chk("R3 ctrl untouched", bus_rdata, 8'h58);
        step(0, 0, 0, 8'hC8, 0, "R3"); chk("R3 src untouched", bus_rdata, 8'h00);
        // R2 write, readback next cycle; R9 switch at boundary
        step(1, 0, 1, 8'hC7, 8'h13, "R2");
        step(0, 0, 0, 8'hC7, 0, "R2"); chk("R2 ctrl readback", bus_rdata, 8'h13);
        step(0, 0, 1, 8'hC8, 8'hFF, "R3");
        step(0, 0, 0, 8'hC8, 0, "R3"); chk("R3 src bit only", bus_rdata, 8'h01);
        // R8 PLL as source, R11 power-down on oscillator
        for (int i = 0; i < 40; i++) step(0, 1, 0, 8'h00, 0, "R8");
        step(0, 0, 1, 8'hC8, 8'h00, "R11");
        for (int i = 0; i < 40; i++) step(0, 1, 0, 8'h00, 0, "R11");
        for (int i = 0; i < 60; i++) begin
            step(0, 1, 0, 8'h00, 0, "R11");
            chk("R11 no ref strobe", {7'd0, pll_ref_stb}, 8'd0);
        end
        // random mix
        for (int i = 0; i < 20000; i++) begin
            logic wr;
            logic [7:0] a;
            wr = ($urandom % 30) == 0;
            case ($urandom % 4)
                0: a = 8'hC7;
                1: a = 8'hC8;
                2: a = 8'hC6;
                default: a = 8'($urandom);
            endcase
            step(($urandom % 10) < 7, ($urandom % 2) == 1, wr, a,
                 8'($urandom % 8 == 0 ? ($urandom & 8'h07) : $urandom), "R9");
        end
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule